// File: doc/BRIEF.md
# Cipher SPI Transfer Port

This block sits between a microcontroller acting as SPI master and a block-cipher engine. The master raises a load line, clocks in a 256-bit frame (a 128-bit plaintext block, then a 128-bit key, most significant bit first, in whole bytes) and lowers load. The port hands both blocks to the engine and pulses a start strobe in the system clock domain. When the engine reports a result, the port latches the 128-bit ciphertext and raises done. The master then clocks the ciphertext back out. The SPI link runs in mode 1: the clock idles low, the master drives on rising edges and samples on falling edges.

The serial registers run on the SPI clock. The controller runs on the system clock and sees load only through a two-stage synchronizer. It is a four-state machine:
- ST_IDLE goes to ST_RECV once the synchronized load is high.
- ST_RECV goes to ST_BUSY (pulsing start) when load drops after a complete frame. It goes back to ST_IDLE when load drops after any other length.
- ST_BUSY goes to ST_DONE when the engine reports ready.
- ST_DONE goes to ST_RECV when load is raised again.

The master waits at least four system clocks after raising load before its first falling SPI edge.

Top module: `cipher_spi_port`

## Requirements
- R1: After reset, hs_done is 0, core_start is 0 and spi_miso is 0.
- R2: While hs_load is high, spi_mosi is sampled on each falling spi_sck edge, MSB first. The last 256 bits received appear on core_ptext (the first 128 of them) and core_key (the last 128).
- R3: hs_load passes through two system-clock flip-flops. core_start is high during the cycle after the second rising clk edge that samples hs_load low.
- R4: core_start fires only if exactly 256 bits (32 bytes) arrived while hs_load was high. A shorter or longer frame gives no start and returns the controller to idle, leaving hs_done low.
- R5: When core_ready is high in ST_BUSY, core_ctext is latched and hs_done rises on the next clk edge.
- R6: In ST_DONE, spi_miso shows ciphertext bit 127 before any spi_sck edge and advances one bit, MSB first, after each falling edge. After 128 bits it reads 0.
- R7: hs_done stays high until the synchronized hs_load is high. It then falls on the following clk edge, that is, the third rising edge that samples hs_load high.
- R8: core_ready outside ST_BUSY has no effect; hs_done stays low in ST_IDLE.
- R9: core_start is high for exactly one clk cycle per accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the master (mode 1) |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial ciphertext to the master |
| hs_load | input | 1 | Master frames the input transfer with this line |
| hs_done | output | 1 | Ciphertext ready for readout |
| core_start | output | 1 | One-cycle start strobe to the engine |
| core_ptext | output | 128 | Plaintext block to the engine |
| core_key | output | 128 | Key block to the engine |
| core_ready | input | 1 | Engine result valid |
| core_ctext | input | 128 | Ciphertext from the engine |

## Verification
A cycle-level model in the bench predicts core_start and hs_done on every clock. The bench drives four frames:
- Two exact 256-bit frames with different data. They show that the bit order and the plaintext/key split are right, and that the counter restarts between frames.
- A 248-bit frame. It separates the byte counter from a simple load edge detector.
- A 264-bit frame. It shows that over-length frames are rejected while the shift window keeps the last 256 bits.

The readout clocks 130 bits, so it exercises both the first-bit-before-edge case and the zero after the last bit. A stray core_ready in idle shows that the handshake ignores results it did not ask for.

// File: rtl/cspi_pkg.sv
package cspi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_BUSY = 2'd2,
        ST_DONE = 2'd3
    } link_state_t;

endpackage

// File: rtl/cspi_sync.sv
module cspi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/cspi_rx.sv
module cspi_rx #(
    parameter int BLOCK_W   = 128,
    parameter int WORD_BITS = 8
) (
    input  logic               spi_sck,
    input  logic               rst_n,
    input  logic               cnt_clr,
    input  logic               load,
    input  logic               mosi,
    output logic [BLOCK_W-1:0] ptext,
    output logic [BLOCK_W-1:0] key,
    output logic               frame_ok
);

    localparam int FRAME_BITS  = 2 * BLOCK_W;
    localparam int FRAME_WORDS = FRAME_BITS / WORD_BITS;
    localparam int IDX_W       = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
    localparam int CNT_W       = $clog2(FRAME_WORDS + 2);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_WORDS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_WORDS + 1);

    logic [FRAME_BITS-1:0] window;
    logic [IDX_W-1:0]      bit_idx;
    logic [CNT_W-1:0]      word_cnt;

    // Sliding window of the most recent frame bits, MSB first.
    always_ff @(negedge spi_sck or negedge rst_n) begin
        if (!rst_n) begin
            window <= '0;
        end else if (load) begin
            window <= {window[FRAME_BITS-2:0], mosi};
        end
    end

    // Byte-framed length counter; cleared by the controller outside reception.
    always_ff @(negedge spi_sck or posedge cnt_clr) begin
        if (cnt_clr) begin
            bit_idx  <= '0;
            word_cnt <= '0;
        end else if (load) begin
            if (bit_idx == IDX_LAST) begin
                bit_idx <= '0;
                if (word_cnt != CNT_SAT) begin
                    word_cnt <= word_cnt + 1'b1;
                end
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    assign ptext    = window[FRAME_BITS-1:BLOCK_W];
    assign key      = window[BLOCK_W-1:0];
    assign frame_ok = (word_cnt == CNT_FULL) && (bit_idx == '0);

    AST_LEN_SATURATES: assert property (@(negedge spi_sck) disable iff (cnt_clr)
        (word_cnt == CNT_SAT) |=> (word_cnt == CNT_SAT)); // R4

endmodule

// File: rtl/cspi_tx.sv
module cspi_tx #(
    parameter int BLOCK_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [BLOCK_W-1:0] ctext_in,
    input  logic               spi_sck,
    input  logic               cnt_clr,
    output logic               miso
);

    localparam int POS_W = $clog2(BLOCK_W + 1);
    localparam logic [POS_W-1:0] POS_END = POS_W'(BLOCK_W);

    logic [BLOCK_W-1:0] ct_hold;
    logic [BLOCK_W-1:0] ct_view;
    logic [POS_W-1:0]   out_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_hold <= '0;
        end else if (capture) begin
            ct_hold <= ctext_in;
        end
    end

    // Bits already delivered; advances after the master samples on the falling edge.
    always_ff @(negedge spi_sck or posedge cnt_clr) begin
        if (cnt_clr) begin
            out_pos <= '0;
        end else if (out_pos != POS_END) begin
            out_pos <= out_pos + 1'b1;
        end
    end

    // A shift by the full width yields zero once every bit has gone out.
    assign ct_view = ct_hold << out_pos;
    assign miso    = ct_view[BLOCK_W-1];

    AST_POS_MONOTONIC: assert property (@(negedge spi_sck) disable iff (cnt_clr)
        (out_pos != '0) |=> (out_pos >= $past(out_pos))); // R6

endmodule

// File: rtl/cspi_ctrl.sv
module cspi_ctrl
    import cspi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_s,
    input  logic frame_ok,
    input  logic core_ready,
    output logic start,
    output logic capture,
    output logic done,
    output logic rx_clr,
    output logic tx_clr
);

    link_state_t state_q;
    link_state_t state_nxt;

    // State register plus the registered counter clears for the SPI-clock side.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rx_clr  <= 1'b1;
            tx_clr  <= 1'b1;
        end else begin
            state_q <= state_nxt;
            rx_clr  <= (state_nxt != ST_RECV);
            tx_clr  <= (state_nxt != ST_DONE);
        end
    end

    // Transitions and outputs.
    always_comb begin
        state_nxt = state_q;
        start     = 1'b0;
        capture   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load_s) begin
                    state_nxt = ST_RECV;
                end
            end
            ST_RECV: begin
                if (!load_s) begin
                    if (frame_ok) begin
                        start     = 1'b1;
                        state_nxt = ST_BUSY;
                    end else begin
                        state_nxt = ST_IDLE;
                    end
                end
            end
            ST_BUSY: begin
                if (core_ready) begin
                    capture   = 1'b1;
                    state_nxt = ST_DONE;
                end
            end
            ST_DONE: begin
                done = 1'b1;
                if (load_s) begin
                    state_nxt = ST_RECV;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start); // R9
    AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(load_s)); // R3
    AST_SHORT_FRAME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECV && !load_s && !frame_ok) |=> (state_q == ST_IDLE && !done)); // R4
    AST_DONE_FOLLOWS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && core_ready) |=> done); // R5
    AST_DONE_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load_s) |=> done); // R7
    AST_READY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && core_ready) |=> !done); // R8

endmodule

// File: rtl/cipher_spi_port.sv
module cipher_spi_port #(
    parameter int BLOCK_W     = 128,
    parameter int WORD_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sck,
    input  logic               spi_mosi,
    output logic               spi_miso,
    input  logic               hs_load,
    output logic               hs_done,
    output logic               core_start,
    output logic [BLOCK_W-1:0] core_ptext,
    output logic [BLOCK_W-1:0] core_key,
    input  logic               core_ready,
    input  logic [BLOCK_W-1:0] core_ctext
);

    logic load_s;
    logic frame_ok;
    logic capture;
    logic rx_clr;
    logic tx_clr;

    cspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (hs_load),
        .q_sync  (load_s)
    );

    cspi_rx #(.BLOCK_W(BLOCK_W), .WORD_BITS(WORD_BITS)) u_rx (
        .spi_sck  (spi_sck),
        .rst_n    (rst_n),
        .cnt_clr  (rx_clr),
        .load     (hs_load),
        .mosi     (spi_mosi),
        .ptext    (core_ptext),
        .key      (core_key),
        .frame_ok (frame_ok)
    );

    cspi_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_s     (load_s),
        .frame_ok   (frame_ok),
        .core_ready (core_ready),
        .start      (core_start),
        .capture    (capture),
        .done       (hs_done),
        .rx_clr     (rx_clr),
        .tx_clr     (tx_clr)
    );

    cspi_tx #(.BLOCK_W(BLOCK_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .ctext_in (core_ctext),
        .spi_sck  (spi_sck),
        .cnt_clr  (tx_clr),
        .miso     (spi_miso)
    );

endmodule

// File: tb/cipher_spi_port_tb.sv
module cipher_spi_port_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic load = 1'b0;
    logic ready_resp = 1'b0;
    logic spur = 1'b0;
    logic core_ready;
    logic [127:0] core_ct = '0;
    logic miso, done, start;
    logic [127:0] ptext, key;

    int checks = 0;
    int errors = 0;
    int nstart = 0;
    int m_bits = 0;
    int cd = 0;

    // Reference model state
    logic m_s1 = 1'b0, m_s2 = 1'b0;
    int m_phase = 0; // 0 idle, 1 receiving, 2 busy, 3 done
    logic exp_start, exp_done;

    assign core_ready = ready_resp | spur;

    always #10 clk = ~clk;

    cipher_spi_port u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso),
        .hs_load(load), .hs_done(done), .core_start(start), .core_ptext(ptext),
        .core_key(key), .core_ready(core_ready), .core_ctext(core_ct)
    );

    function automatic logic [127:0] cipher_of(logic [127:0] p, logic [127:0] k);
        return p ^ {k[63:0], k[127:64]} ^ 128'h5a5a_0f0f_c3c3_9696_1234_5678_9abc_def0;
    endfunction

    task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural model of the handshake timing
    assign exp_start = (m_phase == 1) && !m_s2 && (m_bits == 256);
    assign exp_done  = (m_phase == 3);

    always @(posedge clk) begin
        int nxt;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_phase = 0;
        end else begin
            nxt = m_phase;
            case (m_phase)
                0: if (m_s2) nxt = 1;
                1: if (!m_s2) nxt = (m_bits == 256) ? 2 : 0;
                2: if (core_ready) nxt = 3;
                default: if (m_s2) nxt = 1;
            endcase
            m_phase = nxt;
            m_s2 = m_s1;
            m_s1 = load;
        end
    end

    // Per-clock comparison against the model (R3 R5 R7 R9)
    always @(negedge clk) begin
        if (rst_n) begin
            check(start == exp_start, "R3/R9", "core_start", 128'(start), 128'(exp_start));
            check(done == exp_done, "R5/R7", "hs_done", 128'(done), 128'(exp_done));
            if (start) nstart++;
        end
    end

    // Engine stand-in
    always @(negedge clk) begin
        if (!rst_n) begin
            cd = 0; ready_resp = 0;
        end else begin
            if (start) begin
                cd = 5;
                core_ct = cipher_of(ptext, key);
            end else if (cd > 0) begin
                cd--;
            end
            ready_resp = (cd == 1);
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_frame();
        load = 1'b1;
        m_bits = 0;
        wait_clk(6);
    endtask

    task automatic shift_bits(logic [263:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            sck = 1'b1;
            mosi = v[i];
            wait_clk(4);
            sck = 1'b0;
            m_bits++;
            wait_clk(4);
        end
    endtask

    task automatic end_frame();
        wait_clk(2);
        load = 1'b0;
    endtask

    task automatic read_bits(logic [127:0] exp, int n);
        check(miso == exp[127], "R6", "first bit before edge", 128'(miso), 128'(exp[127]));
        for (int i = 0; i < n; i++) begin
            logic e;
            sck = 1'b1;
            wait_clk(2);
            e = (i < 128) ? exp[127 - i] : 1'b0;
            check(miso == e, "R6", $sformatf("readout bit %0d", i), 128'(miso), 128'(e));
            wait_clk(2);
            sck = 1'b0;
            wait_clk(4);
        end
    endtask

    logic [127:0] pt1 = 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff;
    logic [127:0] k1  = 128'h0001_0203_0405_0607_0809_0a0b_0c0d_0e0f;
    logic [127:0] pt2 = 128'h3243_f6a8_885a_308d_3131_98a2_e037_0734;
    logic [127:0] k2  = 128'h2b7e_1516_28ae_d2a6_abf7_1588_09cf_4f3c;

    initial begin
        int s0;
        wait_clk(5);
        // R1 reset state
        check(done == 0, "R1", "done in reset", 128'(done), 0);
        check(start == 0, "R1", "start in reset", 128'(start), 0);
        check(miso == 0, "R1", "miso in reset", 128'(miso), 0);
        rst_n = 1'b1;
        wait_clk(3);

        // Frame A: exact 256 bits
        s0 = nstart;
        begin_frame();
        shift_bits({8'h00, pt1, k1}, 256);
        end_frame();
        check(ptext == pt1, "R2", "plaintext A", ptext, pt1);
        check(key == k1, "R2", "key A", key, k1);
        wait_clk(15);
        check(nstart == s0 + 1, "R9", "one start A", 128'(nstart), 128'(s0 + 1));
        check(done == 1, "R5", "done after ready A", 128'(done), 1);
        read_bits(cipher_of(pt1, k1), 130);
        wait_clk(20);
        check(done == 1, "R7", "done held", 128'(done), 1);

        // Frame B: 31 bytes, rejected
        s0 = nstart;
        begin_frame();
        shift_bits({8'h00, pt2, k2}, 248);
        end_frame();
        wait_clk(20);
        check(nstart == s0, "R4", "no start short frame", 128'(nstart), 128'(s0));
        check(done == 0, "R4", "done low after short frame", 128'(done), 0);

        // Frame C: 33 bytes, rejected, window keeps last 256 bits
        begin_frame();
        shift_bits({8'ha5, pt2, k2}, 264);
        end_frame();
        wait_clk(20);
        check(nstart == s0, "R4", "no start long frame", 128'(nstart), 128'(s0));
        check(ptext == pt2, "R2", "plaintext window", ptext, pt2);
        check(key == k2, "R2", "key window", key, k2);

        // Stray engine ready in idle
        spur = 1'b1;
        wait_clk(1);
        spur = 1'b0;
        wait_clk(4);
        check(done == 0, "R8", "ready ignored in idle", 128'(done), 0);

        // Frame D: exact frame with new data
        begin_frame();
        shift_bits({8'h00, pt2, k2}, 256);
        end_frame();
        wait_clk(15);
        check(nstart == s0 + 1, "R4", "start after good frame", 128'(nstart), 128'(s0 + 1));
        check(done == 1, "R5", "done after ready D", 128'(done), 1);
        read_bits(cipher_of(pt2, k2), 128);

        wait_clk(5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule